// File: doc/BRIEF.md
# Serial Two-Wire Register Target with SCL-Low Watchdog

This block is an I2C target that runs entirely on a fast system clock. It brings the SCL and SDA lines through a synchroniser and finds their edges. It detects START and STOP conditions and checks the address byte against a fixed 7-bit device address. It answers with acknowledge pulses by pulling SDA low through an open-drain enable. Once addressed, it reads and writes a byte-wide register window through a plain address/data/strobe port.

A write transaction works like this. The first data byte loads an internal register pointer, and every byte after it is written at the pointer, which then advances. A read transaction starts at the current pointer and advances after each byte it fetches. A repeated START switches direction and keeps the pointer. An SCL-low watchdog guards the engine. If SCL is held low for a parameterised number of system clocks during a transaction, the engine drops back to idle and releases SDA. It then ignores the bus until it sees a new START.

The engine states are:
- `ST_IDLE`: waiting for START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE` and `ST_WR_ACK`: receiving a byte and acknowledging it.
- `ST_RD_BYTE`: sending a byte.
- `ST_RD_ACK`: sampling the controller's acknowledge.
- `ST_IGNORE`: addressed elsewhere or finished, waiting for START or STOP.

The transitions are:
- From any state, START goes to `ST_ADDR`.
- From any state, STOP or a watchdog expiry goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` for a write and to `ST_RD_BYTE` for a read.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` on ACK and to `ST_IGNORE` on NACK.

Top module: `i2c_tgt_wdog`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_wr_en` and `reg_rd_en` are 0.
- R2: A transaction begins only with a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, returns the engine to idle. Bytes clocked without a preceding START are neither acknowledged nor written.
- R3: The first byte after START is sent MSB first. Bits [7:1] carry the address and bit 0 is the direction (1 = read). The target acknowledges only when bits [7:1] equal `DEV_ADDR`, by holding SDA low through the ninth SCL high phase. On a mismatch it stays silent until the next START.
- R4: In a write, the first data byte loads the pointer. Each later byte gives exactly one `reg_wr_en` pulse, with `reg_addr` equal to the pointer and `reg_wr_data` equal to the byte. The pointer then increments, wrapping at 2^AW. Every data byte is acknowledged.
- R5: In a read, each byte is fetched with one `reg_rd_en` pulse at `reg_addr` equal to the pointer. It is shifted out MSB first, and the pointer increments after each fetch.
- R6: When the controller does not acknowledge a read byte, the target releases SDA. It stays released, so further clocked bits read as 1, until a START.
- R7: A repeated START (a START with no STOP before it) restarts address matching. The pointer keeps its value.
- R8: If SCL stays low for `TIMEOUT_CYC` consecutive system clocks while a transaction is in progress, the engine returns to idle and releases SDA. Later bytes are ignored until a new START.
- R9: SCL low phases shorter than `TIMEOUT_CYC` clocks do not disturb a transaction.
- R10: Operation is correct for any SCL high and low phase of at least 16 system clocks. This covers both 100 kHz and 400 kHz buses with a system clock of tens of MHz.
- R11: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level as seen at the pad |
| sda_in | input | 1 | SDA line level as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | AW | Register pointer / access address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe; `reg_rd_data` is captured in the same cycle |
| reg_rd_data | input | 8 | Read data for `reg_addr` |

## Verification
The hardest case to reach is a watchdog expiry in the middle of a write. The engine has to be busy, with the pointer already loaded, when SCL freezes low. The expiry also has to be told apart from a merely slow low phase. To get there, the stimulus sends a start, the address and the pointer byte, and then holds SCL low for slightly more than the limit. It then clocks two complete data bytes without a START and expects no ACK and no write strobe. A companion sequence holds SCL low for somewhat less than the limit and expects the write to complete.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W  = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_in;
                    sda_ff <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_in};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_scl_watchdog.sv
module i2c_scl_watchdog #(
    parameter int TIMEOUT_CYC = 3_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic scl_lvl,
    output logic timeout
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!busy || scl_lvl) begin
            low_cnt <= '0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign timeout = busy && !scl_lvl && (low_cnt == LAST);

    // the engine drops busy after expiry, so the pulse lasts one cycle
    AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R8

endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         AW          = 8,
    parameter int         TIMEOUT_CYC = 3_500_000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr_en,
    output logic [7:0]    reg_wr_data,
    output logic          reg_rd_en,
    input  logic [7:0]    reg_rd_data
);

    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] LASTB = BITCNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt, to_evt;

    tgt_state_e            state, state_d;
    logic [BITCNT_W-1:0]   bitcnt, bitcnt_d;
    logic [BYTE_W-1:0]     shreg, shreg_d;
    logic [BYTE_W-1:0]     txreg, txreg_d;
    logic [AW-1:0]         ptr, ptr_d;
    logic                  oe_q, oe_d;
    logic                  rw_q, rw_d;
    logic                  first_q, first_d;
    logic                  mack_q, mack_d;
    logic                  wr_fire, rd_fire;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_scl_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (state != ST_IDLE),
        .scl_lvl (scl_lvl),
        .timeout (to_evt)
    );

    // next-state and datapath decisions
    always_comb begin
        state_d  = state;
        bitcnt_d = bitcnt;
        shreg_d  = shreg;
        txreg_d  = txreg;
        ptr_d    = ptr;
        oe_d     = oe_q;
        rw_d     = rw_q;
        first_d  = first_q;
        mack_d   = mack_q;
        wr_fire  = 1'b0;
        rd_fire  = 1'b0;

        if (to_evt) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_evt) begin
            state_d  = ST_ADDR;
            bitcnt_d = '0;
            oe_d     = 1'b0;
            first_d  = 1'b1;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR: begin
                    if (scl_rise && bitcnt != FULL) begin
                        shreg_d  = {shreg[BYTE_W-2:0], sda_lvl};
                        bitcnt_d = bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            rw_d    = shreg[0];
                            oe_d    = 1'b1;
                            state_d = ST_ADDR_ACK;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_d = '0;
                        if (rw_q) begin
                            rd_fire = 1'b1;
                            txreg_d = reg_rd_data;
                            oe_d    = ~reg_rd_data[BYTE_W-1];
                            ptr_d   = ptr + 1'b1;
                            state_d = ST_RD_BYTE;
                        end else begin
                            oe_d    = 1'b0;
                            state_d = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise && bitcnt != FULL) begin
                        shreg_d  = {shreg[BYTE_W-2:0], sda_lvl};
                        bitcnt_d = bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        oe_d    = 1'b1;
                        state_d = ST_WR_ACK;
                        if (first_q) begin
                            ptr_d   = AW'(shreg);
                            first_d = 1'b0;
                        end else begin
                            wr_fire = 1'b1;
                            ptr_d   = ptr + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        oe_d     = 1'b0;
                        bitcnt_d = '0;
                        state_d  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bitcnt == LASTB) begin
                            oe_d    = 1'b0;
                            state_d = ST_RD_ACK;
                        end else begin
                            txreg_d  = {txreg[BYTE_W-2:0], 1'b0};
                            oe_d     = ~txreg[BYTE_W-2];
                            bitcnt_d = bitcnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            rd_fire  = 1'b1;
                            txreg_d  = reg_rd_data;
                            oe_d     = ~reg_rd_data[BYTE_W-1];
                            ptr_d    = ptr + 1'b1;
                            bitcnt_d = '0;
                            state_d  = ST_RD_BYTE;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state   <= state_d;
            bitcnt  <= bitcnt_d;
            shreg   <= shreg_d;
            txreg   <= txreg_d;
            ptr     <= ptr_d;
            oe_q    <= oe_d;
            rw_q    <= rw_d;
            first_q <= first_d;
            mack_q  <= mack_d;
        end
    end

    // outputs
    always_comb begin
        sda_oe      = oe_q;
        reg_addr    = ptr;
        reg_wr_en   = wr_fire;
        reg_wr_data = shreg;
        reg_rd_en   = rd_fire;
    end

    AST_OE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl); // R11
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !to_evt) |=> (state == ST_IDLE)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !reg_wr_en && !reg_rd_en)); // R2
    AST_ADDR_ACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> sda_oe); // R3
    AST_WR_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_addr == $past(reg_addr) + 1'b1)); // R4
    AST_RD_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> (reg_addr == $past(reg_addr) + 1'b1)); // R5
    AST_MACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe); // R6
    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        to_evt |=> (state == ST_IDLE && !sda_oe)); // R8

endmodule

// File: tb/sim_i2c_tgt_wdog.sv
module sim_i2c_tgt_wdog;

    localparam logic [6:0] ADDR = 7'h3A;
    localparam int         TO   = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic       reg_rd_en;
    logic [7:0] reg_rd_data;
    logic       sda_bus;

    logic [7:0]  mem [0:255];
    logic [15:0] exp_q [$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          hp = 20;

    always #5 clk = ~clk;

    assign sda_bus     = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_addr];

    i2c_tgt_wdog #(.DEV_ADDR(ADDR), .AW(8), .TIMEOUT_CYC(TO)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: every write strobe must match the next queued item
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {reg_addr, reg_wr_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wr_data} == e, "R4 write addr/data",
                      {reg_addr, reg_wr_data}, e);
            end
            mem[reg_addr] = reg_wr_data;
        end
    end

    task automatic do_start();
        sda_m = 1'b0; wcyc(hp);
        scl_m = 1'b0;
    endtask

    task automatic do_rstart();
        wcyc(hp / 2); sda_m = 1'b1; wcyc(hp / 2);
        scl_m = 1'b1; wcyc(hp);
        sda_m = 1'b0; wcyc(hp);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        wcyc(hp / 2); sda_m = 1'b0; wcyc(hp / 2);
        scl_m = 1'b1; wcyc(hp);
        sda_m = 1'b1; wcyc(hp);
    endtask

    task automatic clk_bit(input bit v, output bit s);
        wcyc(hp / 2); sda_m = v; wcyc(hp / 2);
        scl_m = 1'b1; wcyc(hp / 2);
        s = sda_bus; wcyc(hp / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic wr_ack(input logic [7:0] b, input bit exp, input string req);
        bit a;
        send_byte(b, a);
        check(a == exp, req, a, exp);
    endtask

    task automatic rd_chk(input bit give_ack, input logic [7:0] exp, input string req);
        logic [7:0] v;
        recv_byte(give_ack, v);
        check(v == exp, req, v, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
        wcyc(8);
        check(sda_oe == 1'b0 && reg_wr_en == 1'b0 && reg_rd_en == 1'b0, "R1 reset outputs",
              {sda_oe, reg_wr_en, reg_rd_en}, 0);
        rst_n = 1'b1;
        wcyc(10);
        check(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // write burst: pointer 0x10 then three data bytes
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R3 address match ACK");
        wr_ack(8'h10, 1'b1, "R4 pointer byte ACK");
        exp_q.push_back({8'h10, 8'h5C});
        exp_q.push_back({8'h11, 8'hE3});
        exp_q.push_back({8'h12, 8'h01});
        wr_ack(8'h5C, 1'b1, "R4 data ACK 0");
        wr_ack(8'hE3, 1'b1, "R4 data ACK 1");
        wr_ack(8'h01, 1'b1, "R4 data ACK 2");
        do_stop();
        check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);

        // wrong address
        do_start();
        wr_ack({7'h3B, 1'b0}, 1'b0, "R3 mismatch NACK");
        wr_ack(8'h77, 1'b0, "R3 silent after mismatch");
        do_stop();
        check(sda_oe == 1'b0, "R3 released", sda_oe, 0);

        // read from pointer 0x13 (left by the burst)
        do_start();
        wr_ack({ADDR, 1'b1}, 1'b1, "R3 read address ACK");
        rd_chk(1'b1, 8'h13 ^ 8'hA5, "R5 read byte 0");
        rd_chk(1'b0, 8'h14 ^ 8'hA5, "R5 read byte 1");
        rd_chk(1'b0, 8'hFF, "R6 released after NACK");
        do_stop();

        // repeated start: set pointer then read
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R7 write address ACK");
        wr_ack(8'h20, 1'b1, "R7 pointer ACK");
        do_rstart();
        wr_ack({ADDR, 1'b1}, 1'b1, "R7 read address after Sr");
        rd_chk(1'b0, 8'h20 ^ 8'hA5, "R7 read at kept pointer");
        do_stop();

        // watchdog expiry mid-write
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R8 address ACK");
        wr_ack(8'h30, 1'b1, "R8 pointer ACK");
        wcyc(TO + 50);
        check(sda_oe == 1'b0, "R8 released on timeout", sda_oe, 0);
        wr_ack(8'hAB, 1'b0, "R8 ignored after timeout 0");
        wr_ack(8'hCD, 1'b0, "R8 ignored after timeout 1");
        do_stop();
        // bytes with no START at all
        scl_m = 1'b0;
        wr_ack({ADDR, 1'b0}, 1'b0, "R2 no START no ACK");
        do_stop();
        check(mem[8'h30] == (8'h30 ^ 8'hA5), "R8 memory untouched", mem[8'h30], 8'h30 ^ 8'hA5);

        // long but legal low phase
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R9 address ACK");
        wr_ack(8'h40, 1'b1, "R9 pointer ACK");
        exp_q.push_back({8'h40, 8'h11});
        exp_q.push_back({8'h41, 8'h22});
        wr_ack(8'h11, 1'b1, "R9 data ACK 0");
        wcyc(TO - 100);
        wr_ack(8'h22, 1'b1, "R9 data ACK after long low");
        do_stop();
        check(exp_q.size() == 0, "R9 writes seen", exp_q.size(), 0);

        // slow bus
        hp = 100;
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R10 slow address ACK");
        wr_ack(8'h50, 1'b1, "R10 slow pointer ACK");
        exp_q.push_back({8'h50, 8'h99});
        wr_ack(8'h99, 1'b1, "R10 slow data ACK");
        do_stop();
        do_start();
        wr_ack({ADDR, 1'b0}, 1'b1, "R10 slow address ACK 2");
        wr_ack(8'h50, 1'b1, "R10 slow pointer ACK 2");
        do_rstart();
        wr_ack({ADDR, 1'b1}, 1'b1, "R10 slow read address");
        rd_chk(1'b0, 8'h99, "R10 slow readback");
        do_stop();
        check(exp_q.size() == 0, "R10 writes seen", exp_q.size(), 0);
        check(sda_oe == 1'b0, "R11 idle release", sda_oe, 0);

        wcyc(20);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule